// File: doc/BRIEF.md
# Stop-Bit Bundle Assembler and Placement Checker

This block sits behind an instruction fetch path that delivers 64-bit chunks, each holding two 32-bit syllables. Every syllable carries an end marker in its top bit. The block walks the syllables in address order, one per clock, and collects them into a variable-length bundle. The bundle closes at the first syllable whose end marker is set. Because of this, no filler operations are needed between bundles. A bundle may start in one chunk and end in the next. It is released only once its closing syllable has been taken.

Each bundle is checked against the placement rules for its slots as it is assembled:
- a control-flow operation may only occupy the first slot;
- a multiply may only sit at an odd word address;
- an immediate extension may only sit at an even word address;
- no more than one operation may use the load/store unit.

The operation class comes from a 4-bit major opcode in bits 30:27. The finished bundle is presented on a valid/ready output as a slot array, a syllable count, a rule-violation flag and an overflow flag. When the output is held, assembly stops and the chunk input deasserts its ready.

Top module: `syl_bundler`

## Requirements
- R1: A syllable with bit 31 set closes the current bundle. Slot 0 holds the earliest syllable, and `bnd_count_o` gives the number of syllables in the bundle (1 to 4).
- R2: Chunks are aligned to even word addresses. The low half (bits 31:0) is at the even address and is consumed first; the high half is at the odd address. A bundle that spans chunks is emitted once, with its syllables in order.
- R3: If four syllables arrive and none has bit 31 set, the bundle closes with `bnd_ovf_o`=1 and count 4, and the next syllable starts a new bundle.
- R4: A control-flow syllable (opcode 4'hC) in any slot other than slot 0 sets `bnd_viol_o`. In slot 0 it is legal.
- R5: A multiply syllable (opcode 4'hD) at an even word address sets `bnd_viol_o`. At an odd address it is legal.
- R6: An immediate-extension syllable (opcode 4'hE) at an odd word address sets `bnd_viol_o`. At an even address it is legal.
- R7: A bundle with more than one load (4'hA) or store (4'hB) syllable, counted together, sets `bnd_viol_o`. Exactly one is legal.
- R8: Slots at or above the count read as zero. A bundle that breaks no rule has `bnd_viol_o`=0 and `bnd_ovf_o`=0 unless R3 applies.
- R9: While `bnd_valid_o`=1 and `bnd_ready_i`=0, all bundle outputs hold steady and, once the assembler is blocked, `chunk_ready_o` is low.
- R10: After reset, `bnd_valid_o`=0 and `chunk_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chunk_valid_i | input | 1 | Fetch chunk offered |
| chunk_ready_o | output | 1 | Chunk accepted this cycle when high with valid |
| chunk_data_i | input | 64 | Two syllables, low half at even word address |
| bnd_valid_o | output | 1 | Bundle available |
| bnd_ready_i | input | 1 | Consumer takes the bundle |
| bnd_slots_o | output | 128 | Slot array, slot i at bits 32*i+31:32*i |
| bnd_count_o | output | 3 | Syllables in bundle |
| bnd_viol_o | output | 1 | A placement rule was broken |
| bnd_ovf_o | output | 1 | Bundle closed by the four-syllable cap |

## Verification
The main stream covers the following cases:
- one-syllable bundles back to back, which tests closing on the end marker alone;
- two-slot bundles inside one chunk, and four-slot bundles that cross a chunk boundary, which show that partial bundles are carried across fetches;
- capped bundles with no end marker, which show that overflow closes the bundle and that the following syllable opens a fresh one.

Each placement rule is tried in a legal and an illegal position, so that the parity and slot-0 checks are told apart from a blanket flag on the opcode. The output is throttled in a repeating pattern, and then held low for a long stretch, to show that stalled bundles stay intact and that the chunk input stops.

// File: rtl/syl_pkg.sv
package syl_pkg;
  localparam int SYL_W    = 32;
  localparam int STOP_BIT = 31;
  localparam int OP_HI    = 30;
  localparam int OP_LO    = 27;

  localparam logic [3:0] OP_LOAD  = 4'hA;
  localparam logic [3:0] OP_STORE = 4'hB;
  localparam logic [3:0] OP_CTRL  = 4'hC;
  localparam logic [3:0] OP_MUL   = 4'hD;
  localparam logic [3:0] OP_IMMX  = 4'hE;

  typedef struct packed {
    logic ctrl;
    logic mul;
    logic immx;
    logic ls;
  } syl_class_t;

  function automatic syl_class_t classify(logic [3:0] op);
    syl_class_t c;
    c.ctrl = (op == OP_CTRL);
    c.mul  = (op == OP_MUL);
    c.immx = (op == OP_IMMX);
    c.ls   = (op == OP_LOAD) || (op == OP_STORE);
    return c;
  endfunction
endpackage

// File: rtl/syl_unpack.sv
module syl_unpack #(
  parameter int CHUNK_SYL = 2,
  localparam int PW = (CHUNK_SYL > 1) ? $clog2(CHUNK_SYL) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         chunk_valid_i,
  output logic                         chunk_ready_o,
  input  logic [CHUNK_SYL*32-1:0]      chunk_data_i,
  output logic                         syl_valid_o,
  output logic [31:0]                  syl_o,
  output logic                         syl_odd_o,
  input  logic                         syl_take_i
);
  logic [CHUNK_SYL-1:0][31:0] sbuf_q;
  logic [PW-1:0]              ptr_q;
  logic                       full_q;
  logic                       last;

  assign last          = (ptr_q == PW'(CHUNK_SYL - 1));
  assign chunk_ready_o = !full_q || (syl_take_i && last);
  assign syl_valid_o   = full_q;
  assign syl_o         = sbuf_q[ptr_q];
  // chunk base is even-aligned, so parity follows the in-chunk index
  assign syl_odd_o     = ptr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbuf_q <= '0;
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (chunk_valid_i && chunk_ready_o) begin
      sbuf_q <= chunk_data_i;
      ptr_q  <= '0;
      full_q <= 1'b1;
    end else if (syl_take_i) begin
      if (last) full_q <= 1'b0;
      else      ptr_q  <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/syl_rules.sv
module syl_rules
  import syl_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       odd_i,
  input  logic       first_i,
  input  logic       ls_seen_i,
  output logic       bad_o,
  output logic       is_ls_o
);
  syl_class_t c;

  always_comb begin
    c       = classify(op_i);
    is_ls_o = c.ls;
    bad_o   = (c.ctrl && !first_i)
            | (c.mul  && !odd_i)
            | (c.immx &&  odd_i)
            | (c.ls   &&  ls_seen_i);
  end
endmodule

// File: rtl/syl_asm.sv
module syl_asm
  import syl_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   syl_valid_i,
  input  logic [31:0]            syl_i,
  output logic                   syl_take_o,
  input  logic                   bad_i,
  input  logic                   is_ls_i,
  output logic                   first_o,
  output logic                   ls_seen_o,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [NSLOT*32-1:0]    out_slots_o,
  output logic [CW-1:0]          out_count_o,
  output logic                   out_viol_o,
  output logic                   out_ovf_o
);
  logic [NSLOT-1:0][31:0] acc_q, out_q;
  logic [CW-1:0]          cnt_q, ocnt_q;
  logic                   ls_q, viol_q;
  logic                   ovalid_q, oviol_q, oovf_q;
  logic                   stop, cap, close;

  assign stop       = syl_i[STOP_BIT];
  assign cap        = (cnt_q == CW'(NSLOT - 1));
  assign close      = stop || cap;
  assign syl_take_o = syl_valid_i && (!close || !ovalid_q || out_ready_i);
  assign first_o    = (cnt_q == '0);
  assign ls_seen_o  = ls_q;

  assign out_valid_o = ovalid_q;
  assign out_slots_o = out_q;
  assign out_count_o = ocnt_q;
  assign out_viol_o  = oviol_q;
  assign out_ovf_o   = oovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      out_q    <= '0;
      cnt_q    <= '0;
      ocnt_q   <= '0;
      ls_q     <= 1'b0;
      viol_q   <= 1'b0;
      ovalid_q <= 1'b0;
      oviol_q  <= 1'b0;
      oovf_q   <= 1'b0;
    end else begin
      if (ovalid_q && out_ready_i) ovalid_q <= 1'b0;
      if (syl_take_o) begin
        if (close) begin
          for (int i = 0; i < NSLOT; i++)
            out_q[i] <= (CW'(i) == cnt_q) ? syl_i : acc_q[i];
          ocnt_q   <= cnt_q + 1'b1;
          oviol_q  <= viol_q | bad_i;
          oovf_q   <= !stop;
          ovalid_q <= 1'b1;
          acc_q    <= '0;
          cnt_q    <= '0;
          ls_q     <= 1'b0;
          viol_q   <= 1'b0;
        end else begin
          for (int i = 0; i < NSLOT; i++)
            if (CW'(i) == cnt_q) acc_q[i] <= syl_i;
          cnt_q  <= cnt_q + 1'b1;
          ls_q   <= ls_q | is_ls_i;
          viol_q <= viol_q | bad_i;
        end
      end
    end
  end
endmodule

// File: rtl/syl_bundler.sv
module syl_bundler
  import syl_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int CHUNK_SYL = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            chunk_valid_i,
  output logic                            chunk_ready_o,
  input  logic [CHUNK_SYL*32-1:0]         chunk_data_i,
  output logic                            bnd_valid_o,
  input  logic                            bnd_ready_i,
  output logic [NSLOT*32-1:0]             bnd_slots_o,
  output logic [$clog2(NSLOT+1)-1:0]      bnd_count_o,
  output logic                            bnd_viol_o,
  output logic                            bnd_ovf_o
);
  logic        syl_valid, syl_odd, syl_take;
  logic [31:0] syl;
  logic        bad, is_ls, first, ls_seen;

  syl_unpack #(.CHUNK_SYL(CHUNK_SYL)) u_unpack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .chunk_valid_i (chunk_valid_i),
    .chunk_ready_o (chunk_ready_o),
    .chunk_data_i  (chunk_data_i),
    .syl_valid_o   (syl_valid),
    .syl_o         (syl),
    .syl_odd_o     (syl_odd),
    .syl_take_i    (syl_take)
  );

  syl_rules u_rules (
    .op_i      (syl[OP_HI:OP_LO]),
    .odd_i     (syl_odd),
    .first_i   (first),
    .ls_seen_i (ls_seen),
    .bad_o     (bad),
    .is_ls_o   (is_ls)
  );

  syl_asm #(.NSLOT(NSLOT)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .syl_valid_i (syl_valid),
    .syl_i       (syl),
    .syl_take_o  (syl_take),
    .bad_i       (bad),
    .is_ls_i     (is_ls),
    .first_o     (first),
    .ls_seen_o   (ls_seen),
    .out_valid_o (bnd_valid_o),
    .out_ready_i (bnd_ready_i),
    .out_slots_o (bnd_slots_o),
    .out_count_o (bnd_count_o),
    .out_viol_o  (bnd_viol_o),
    .out_ovf_o   (bnd_ovf_o)
  );
endmodule

// File: rtl/syl_bundler_chk.sv
module syl_bundler_chk
  import syl_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       bnd_valid_o,
  input logic                       bnd_ready_i,
  input logic [NSLOT*32-1:0]        bnd_slots_o,
  input logic [$clog2(NSLOT+1)-1:0] bnd_count_o,
  input logic                       bnd_viol_o,
  input logic                       bnd_ovf_o
);
  localparam int CW = $clog2(NSLOT + 1);

  logic [NSLOT-1:0] stop_in;
  logic             last_stop, pad_dirty, ctrl_late;
  logic [CW-1:0]    ls_n;
  logic [31:0]      s;

  always_comb begin
    stop_in   = '0;
    last_stop = 1'b0;
    pad_dirty = 1'b0;
    ctrl_late = 1'b0;
    ls_n      = '0;
    for (int i = 0; i < NSLOT; i++) begin
      s = bnd_slots_o[i*32 +: 32];
      if (CW'(i) < bnd_count_o) begin
        stop_in[i] = s[STOP_BIT];
        if (i > 0 && s[OP_HI:OP_LO] == OP_CTRL) ctrl_late = 1'b1;
        if (s[OP_HI:OP_LO] == OP_LOAD || s[OP_HI:OP_LO] == OP_STORE) ls_n = ls_n + 1'b1;
      end else if (s != '0) begin
        pad_dirty = 1'b1;
      end
      if (CW'(i + 1) == bnd_count_o) last_stop = s[STOP_BIT];
    end
  end

  p_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_valid_o |-> (bnd_count_o != '0) && (bnd_count_o <= CW'(NSLOT)));

  p_stop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_valid_o && !bnd_ovf_o |-> last_stop && ($countones(stop_in) == 1));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_valid_o && bnd_ovf_o |-> (bnd_count_o == CW'(NSLOT)) && (stop_in == '0));

  p_ctrl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_valid_o && ctrl_late |-> bnd_viol_o);

  p_ls_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_valid_o && (ls_n > CW'(1)) |-> bnd_viol_o);

  p_pad_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_valid_o |-> !pad_dirty);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_valid_o && !bnd_ready_i |=> bnd_valid_o && $stable(bnd_slots_o)
      && $stable(bnd_count_o) && $stable(bnd_viol_o) && $stable(bnd_ovf_o));
endmodule

bind syl_bundler syl_bundler_chk #(.NSLOT(NSLOT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bnd_valid_o (bnd_valid_o),
  .bnd_ready_i (bnd_ready_i),
  .bnd_slots_o (bnd_slots_o),
  .bnd_count_o (bnd_count_o),
  .bnd_viol_o  (bnd_viol_o),
  .bnd_ovf_o   (bnd_ovf_o)
);

// File: tb/sim_syl_bundler.sv
`timescale 1ns/1ps
module sim_syl_bundler;
  localparam int NSLOT = 4;
  localparam int NCH   = 14;
  localparam int NB    = 15;
  localparam logic [3:0] ALU = 4'h1, LD = 4'hA, ST = 4'hB, CT = 4'hC, MU = 4'hD, IX = 4'hE;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         chunk_valid_i = 1'b0, bnd_ready_i = 1'b0;
  logic [63:0]  chunk_data_i = '0;
  logic         chunk_ready_o, bnd_valid_o, bnd_viol_o, bnd_ovf_o;
  logic [127:0] bnd_slots_o;
  logic [2:0]   bnd_count_o;

  always #4 clk_i = ~clk_i;

  syl_bundler u0 (.*);

  function automatic logic [31:0] sy(logic s, logic [3:0] op, int tag);
    return {s, op, 27'(tag)};
  endfunction
  // {req[3:0], count[2:0], viol, ovf}
  function automatic logic [8:0] ex(int req, int cnt, logic v, logic o);
    return {4'(req), 3'(cnt), v, o};
  endfunction

  // each chunk is {high(odd), low(even)}
  localparam logic [63:0] CHUNKS [NCH] = '{
    {sy(1, ALU, 2),  sy(1, ALU, 1)},   // two single bundles
    {sy(1, MU, 4),   sy(0, ALU, 3)},   // mul at odd: legal
    {sy(0, ALU, 6),  sy(0, IX, 5)},    // immx at even, spans chunks
    {sy(1, ALU, 8),  sy(0, ALU, 7)},
    {sy(0, ALU, 10), sy(0, ALU, 9)},   // cap reached, no stop
    {sy(0, ALU, 12), sy(0, ALU, 11)},
    {sy(1, CT, 14),  sy(0, CT, 13)},   // ctrl in slot 1
    {sy(1, IX, 16),  sy(1, MU, 15)},   // mul even, immx odd
    {sy(1, ST, 18),  sy(0, LD, 17)},   // two load/store
    {sy(1, ALU, 20), sy(0, LD, 19)},   // one load/store
    {sy(1, CT, 22),  sy(1, CT, 21)},   // ctrl in slot 0
    {sy(0, ALU, 24), sy(0, ALU, 23)},
    {sy(0, ALU, 26), sy(0, ALU, 25)},
    {sy(1, ALU, 28), sy(1, ALU, 27)}   // fresh bundles after cap
  };

  localparam logic [8:0] EXP [NB] = '{
    ex(1, 1, 0, 0), ex(1, 1, 0, 0),    // R1
    ex(5, 2, 0, 0),                    // R5 legal
    ex(2, 4, 0, 0),                    // R2 spanning, R6 legal
    ex(3, 4, 0, 1),                    // R3
    ex(4, 2, 1, 0),                    // R4
    ex(5, 1, 1, 0),                    // R5
    ex(6, 1, 1, 0),                    // R6
    ex(7, 2, 1, 0), ex(7, 2, 0, 0),    // R7
    ex(4, 1, 0, 0), ex(4, 1, 0, 0),    // R4 slot 0 legal
    ex(3, 4, 0, 1),                    // R3
    ex(3, 1, 0, 0), ex(3, 1, 0, 0)     // R3 next bundle fresh
  };

  int checks = 0, fails = 0, cyc = 0, pos = 0;
  logic [127:0] got_s;
  logic [2:0]   got_c;
  logic         got_v, got_o;

  function automatic logic [31:0] strm(int k);
    return CHUNKS[k/2][(k%2)*32 +: 32];
  endfunction

  task automatic chk(logic ok, int req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_accept();
    logic r;
    forever begin
      #2; r = chunk_ready_o;
      @(negedge clk_i);
      if (r) break;
    end
    chunk_valid_i = 1'b0;
  endtask

  task automatic send(logic [63:0] d);
    @(negedge clk_i);
    chunk_valid_i = 1'b1;
    chunk_data_i  = d;
    wait_accept();
  endtask

  task automatic get(logic throttle);
    forever begin
      @(negedge clk_i);
      cyc++;
      bnd_ready_i = throttle ? (cyc % 3 != 1) : 1'b1;
      #2;
      if (bnd_valid_o && bnd_ready_i) break;
    end
    got_s = bnd_slots_o; got_c = bnd_count_o; got_v = bnd_viol_o; got_o = bnd_ovf_o;
  endtask

  // slots checked against the stream; padding must be zero (R8)
  task automatic cmp_bundle(int req, int cnt, logic v, logic o);
    logic [127:0] es = '0;
    for (int i = 0; i < cnt; i++) es[i*32 +: 32] = strm(pos + i);
    pos += cnt;
    chk({got_c, got_v, got_o} == {3'(cnt), v, o}, req,
        128'({got_c, got_v, got_o}), 128'({3'(cnt), v, o}));
    chk(got_s == es, 8, got_s, es);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    // R10 reset state
    chk(bnd_valid_o == 1'b0, 10, 128'(bnd_valid_o), 128'(0));
    chk(chunk_ready_o == 1'b1, 10, 128'(chunk_ready_o), 128'(1));

    fork
      for (int c = 0; c < NCH; c++) send(CHUNKS[c]);
      for (int b = 0; b < NB; b++) begin
        get(1'b1);
        cmp_bundle(int'(EXP[b][8:5]), int'(EXP[b][4:2]), EXP[b][1], EXP[b][0]);
      end
    join
    @(negedge clk_i);
    bnd_ready_i = 1'b0;

    // R9 stall: X accepted, Y blocked behind held bundle
    send({sy(1, ALU, 30), sy(1, ALU, 29)});
    chunk_valid_i = 1'b1;
    chunk_data_i  = {sy(1, ALU, 32), sy(1, ALU, 31)};
    repeat (6) @(negedge clk_i);
    #2;
    chk(bnd_valid_o == 1'b1, 9, 128'(bnd_valid_o), 128'(1));
    chk(bnd_slots_o == 128'(sy(1, ALU, 29)), 9, bnd_slots_o, 128'(sy(1, ALU, 29)));
    chk(chunk_ready_o == 1'b0, 9, 128'(chunk_ready_o), 128'(0));
    held = bnd_slots_o;
    repeat (3) @(negedge clk_i);
    #2;
    chk(bnd_valid_o && bnd_slots_o == held && bnd_count_o == 3'd1, 9, bnd_slots_o, held);
    @(negedge clk_i);
    pos = 0;
    fork
      wait_accept();
      for (int b = 0; b < 4; b++) begin
        logic [127:0] es;
        get(1'b0);
        es = 128'(sy(1, ALU, 29 + b));
        chk(got_c == 3'd1 && !got_v && !got_o && got_s == es, 9, got_s, es);  // R9 order kept
      end
    join
    @(negedge clk_i);
    bnd_ready_i = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule